// File: doc/BRIEF.md
# Tile Rotate and Z-Order Swizzle Engine

This engine takes one image tile at a time, eight pixels wide and one to eight rows tall, and reorders it for a block-linear frame layout. Pixels arrive as 32-bit words in raster order and are stored in one of two local banks. Once a tile is complete, it is read back in one of four rotated orders: 0, 90, 180 or 270 degrees. Each emitted word carries a 6-bit destination index. That index is either the plain output step number or the Z-order (Morton) position of that step within the 8x8 block.

A surrounding pipeline streams pixels in with a valid/ready handshake and drains a second valid/ready stream of (pixel, destination index) pairs. It writes each pair to its index in the destination tile. Because there are two banks, the next tile can be loaded while the previous one drains. A single-cycle completion pulse marks the end of each tile.

Two state machines run the engine. The loader has LD_IDLE and LD_FILL. It moves LD_IDLE to LD_FILL when the first pixel of a tile is accepted, latching that tile's configuration. It moves LD_FILL back to LD_IDLE when the tile's last pixel is accepted, marking the bank full and switching to the other bank. The reader has RD_IDLE, RD_EMIT and RD_DONE. It moves RD_IDLE to RD_EMIT when its current bank is full. It moves RD_EMIT to RD_DONE when the last entry is accepted downstream. It always moves RD_DONE to RD_IDLE after one cycle, freeing the bank and switching to the other one.

Top module: `tile_rotswz`

## Requirements
- R1: After reset, in_ready is 1 while out_valid and tile_done are 0.
- R2: A tile consists of (cfg_rows_m1+1)*8 input words in raster order, where input entry n = row*8 + column. cfg_rot, cfg_zorder and cfg_rows_m1 are sampled only with the tile's first accepted word, so later changes during that tile have no effect on it.
- R3: With cfg_rot=0 (0 degrees), output step k carries input entry k.
- R4: With cfg_rot=1 (90 degrees), the output walks columns x from 0 to 7 and, inside each column, rows y from h-1 down to 0, carrying entry y*8+x, where h = cfg_rows_m1+1.
- R5: With cfg_rot=2 (180 degrees), output step k carries input entry h*8-1-k.
- R6: With cfg_rot=3 (270 degrees), the output walks columns x from 7 down to 0 and, inside each column, rows y from 0 up to h-1, carrying entry y*8+x.
- R7: With cfg_zorder=0 (linear), out_idx equals the output step number k.
- R8: With cfg_zorder=1 (block), out_idx interleaves bits: bits 0, 2, 4 are k[0], k[1], k[2] and bits 1, 3, 5 are k[3], k[4], k[5]. The first output row therefore maps to 0,1,4,5,16,17,20,21 and the second to 2,3,6,7,18,19,22,23.
- R9: A tile of h rows emits exactly h*8 entries. out_valid is 0 in the cycle after its last entry.
- R10: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_idx hold.
- R11: tile_done is high for exactly one cycle, the cycle right after the handshake of a tile's last entry.
- R12: A second tile may be loaded while the first drains. When both banks hold undrained tiles, in_ready is 0 until a tile completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rot | input | 2 | Rotation: 0=0, 1=90, 2=180, 3=270 degrees |
| cfg_zorder | input | 1 | 1 selects Z-order destination index, 0 linear |
| cfg_rows_m1 | input | 3 | Valid rows of the tile minus one |
| in_valid | input | 1 | Input word valid |
| in_data | input | DATA_W | Input pixel word, raster order |
| in_ready | output | 1 | Engine can accept an input word |
| out_valid | output | 1 | Output entry valid |
| out_ready | input | 1 | Downstream accepts the output entry |
| out_data | output | DATA_W | Output pixel word |
| out_idx | output | 6 | Destination index of the output entry |
| tile_done | output | 1 | One-cycle pulse after a tile's last entry |

## Verification
The properties check on every cycle that a stalled output entry stays frozen, that the completion pulse lasts exactly one cycle and never coincides with a valid entry, and that each tile emits a nonzero multiple of eight entries, at most 64. Only the bench's scenarios can show that each rotation reads the correct source entries, that the destination index follows the linear or Z-order map, that configuration changes during a tile are ignored, and that bank hand-over stalls and releases input correctly.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
    localparam int unsigned COL_W        = 3;
    localparam int unsigned ROW_W        = 3;
    localparam int unsigned IDX_W        = COL_W + ROW_W;
    localparam int unsigned TILE_ENTRIES = 1 << IDX_W;
    localparam int unsigned NBANK        = 2;
    localparam int unsigned BANK_W       = $clog2(NBANK);
    localparam logic [COL_W-1:0] COL_MAX = '1;

    typedef enum logic [1:0] {
        ROT_0   = 2'd0,
        ROT_90  = 2'd1,
        ROT_180 = 2'd2,
        ROT_270 = 2'd3
    } rot_e;

    typedef struct packed {
        rot_e             rot;
        logic             zorder;
        logic [ROW_W-1:0] rows_m1;
    } tile_cfg_t;

    typedef enum logic {
        LD_IDLE = 1'b0,
        LD_FILL = 1'b1
    } ld_state_e;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_EMIT = 2'd1,
        RD_DONE = 2'd2
    } rd_state_e;
endpackage

// File: rtl/tsw_bank.sv
module tsw_bank #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 64,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tsw_addr_map.sv
module tsw_addr_map
    import tsw_pkg::*;
(
    input  tile_cfg_t        cfg,
    input  logic [IDX_W-1:0] step,
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    output logic [IDX_W-1:0] src,
    output logic [IDX_W-1:0] dst
);
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] z_idx;
    logic [ROW_W-1:0] row_rev;
    logic [COL_W-1:0] col_rev;

    assign last_idx = {cfg.rows_m1, COL_MAX};
    assign row_rev  = cfg.rows_m1 - row;
    assign col_rev  = COL_MAX - col;

    // Source entry for the current output step, per rotation.
    always_comb begin
        unique case (cfg.rot)
            ROT_0:   src = step;
            ROT_90:  src = {row_rev, col};
            ROT_180: src = last_idx - step;
            ROT_270: src = {row, col_rev};
            default: src = step;
        endcase
    end

    // Z-order: column bits on even positions, row bits on odd positions.
    for (genvar b = 0; b < COL_W; b++) begin : g_zbits
        assign z_idx[2*b]   = step[b];
        assign z_idx[2*b+1] = step[COL_W+b];
    end

    assign dst = cfg.zorder ? z_idx : step;
endmodule

// File: rtl/tsw_loader.sv
module tsw_loader
    import tsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ROW_W-1:0]  rows_m1,
    input  logic [NBANK-1:0]  bank_full,
    output logic              in_ready,
    output logic              wr_en,
    output logic [BANK_W-1:0] wr_bank,
    output logic [IDX_W-1:0]  wr_addr,
    output logic              cfg_we,
    output logic              tile_loaded
);
    ld_state_e         st_q, st_d;
    logic [IDX_W-1:0]  cnt_q, cnt_d;
    logic [ROW_W-1:0]  rows_q, rows_d;
    logic [BANK_W-1:0] wsel_q, wsel_d;
    logic              accept;
    logic              at_end;

    assign accept = in_valid && !bank_full[wsel_q];
    assign at_end = (st_q == LD_FILL) && (cnt_q == {rows_q, COL_MAX});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= LD_IDLE;
            cnt_q  <= '0;
            rows_q <= '0;
            wsel_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            rows_q <= rows_d;
            wsel_q <= wsel_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        rows_d = rows_q;
        wsel_d = wsel_q;
        unique case (st_q)
            LD_IDLE: begin
                if (accept) begin
                    st_d   = LD_FILL;
                    cnt_d  = IDX_W'(1);
                    rows_d = rows_m1;
                end
            end
            LD_FILL: begin
                if (accept) begin
                    if (at_end) begin
                        st_d   = LD_IDLE;
                        cnt_d  = '0;
                        wsel_d = wsel_q + 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: st_d = LD_IDLE;
        endcase
    end

    always_comb begin
        in_ready    = !bank_full[wsel_q];
        wr_en       = accept;
        wr_bank     = wsel_q;
        wr_addr     = cnt_q;
        cfg_we      = accept && (st_q == LD_IDLE);
        tile_loaded = accept && at_end;
    end
endmodule

// File: rtl/tsw_reader.sv
module tsw_reader
    import tsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NBANK-1:0]  bank_full,
    input  tile_cfg_t         bank_cfg,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_idx,
    output logic              tile_done,
    output logic [BANK_W-1:0] rd_bank,
    output logic [IDX_W-1:0]  rd_src,
    output logic              bank_release
);
    rd_state_e         st_q, st_d;
    logic [IDX_W-1:0]  k_q, k_d;
    logic [COL_W-1:0]  col_q, col_d;
    logic [ROW_W-1:0]  row_q, row_d;
    logic [BANK_W-1:0] rsel_q, rsel_d;
    tile_cfg_t         cfg_q, cfg_d;
    logic              last;
    logic [IDX_W-1:0]  map_src;
    logic [IDX_W-1:0]  map_dst;

    assign last = (k_q == {cfg_q.rows_m1, COL_MAX});

    tsw_addr_map map_i (
        .cfg  (cfg_q),
        .step (k_q),
        .col  (col_q),
        .row  (row_q),
        .src  (map_src),
        .dst  (map_dst)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= RD_IDLE;
            k_q    <= '0;
            col_q  <= '0;
            row_q  <= '0;
            rsel_q <= '0;
            cfg_q  <= '0;
        end else begin
            st_q   <= st_d;
            k_q    <= k_d;
            col_q  <= col_d;
            row_q  <= row_d;
            rsel_q <= rsel_d;
            cfg_q  <= cfg_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        k_d    = k_q;
        col_d  = col_q;
        row_d  = row_q;
        rsel_d = rsel_q;
        cfg_d  = cfg_q;
        unique case (st_q)
            RD_IDLE: begin
                if (bank_full[rsel_q]) begin
                    st_d  = RD_EMIT;
                    cfg_d = bank_cfg;
                    k_d   = '0;
                    col_d = '0;
                    row_d = '0;
                end
            end
            RD_EMIT: begin
                if (out_ready) begin
                    if (last) begin
                        st_d = RD_DONE;
                    end else begin
                        k_d = k_q + 1'b1;
                        if (row_q == cfg_q.rows_m1) begin
                            row_d = '0;
                            col_d = col_q + 1'b1;
                        end else begin
                            row_d = row_q + 1'b1;
                        end
                    end
                end
            end
            RD_DONE: begin
                st_d   = RD_IDLE;
                rsel_d = rsel_q + 1'b1;
            end
            default: st_d = RD_IDLE;
        endcase
    end

    always_comb begin
        out_valid    = (st_q == RD_EMIT);
        out_idx      = map_dst;
        tile_done    = (st_q == RD_DONE);
        bank_release = (st_q == RD_DONE);
        rd_bank      = rsel_q;
        rd_src       = map_src;
    end
endmodule

// File: rtl/tile_rotswz.sv
module tile_rotswz
    import tsw_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_rot,
    input  logic              cfg_zorder,
    input  logic [2:0]        cfg_rows_m1,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [5:0]        out_idx,
    output logic              tile_done
);
    tile_cfg_t         cfg_in;
    tile_cfg_t         bank_cfg_q [NBANK];
    logic [NBANK-1:0]  bank_full_q, bank_full_d;
    logic              wr_en;
    logic [BANK_W-1:0] wr_bank;
    logic [IDX_W-1:0]  wr_addr;
    logic              cfg_we;
    logic              tile_loaded;
    logic [BANK_W-1:0] rd_bank;
    logic [IDX_W-1:0]  rd_src;
    logic              bank_release;
    logic [DATA_W-1:0] bank_rdata [NBANK];

    assign cfg_in = '{rot: rot_e'(cfg_rot), zorder: cfg_zorder, rows_m1: cfg_rows_m1};

    tsw_loader loader_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .rows_m1     (cfg_rows_m1),
        .bank_full   (bank_full_q),
        .in_ready    (in_ready),
        .wr_en       (wr_en),
        .wr_bank     (wr_bank),
        .wr_addr     (wr_addr),
        .cfg_we      (cfg_we),
        .tile_loaded (tile_loaded)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        tsw_bank #(
            .DATA_W (DATA_W),
            .DEPTH  (TILE_ENTRIES)
        ) bank_i (
            .clk   (clk),
            .we    (wr_en && (wr_bank == BANK_W'(b))),
            .waddr (wr_addr),
            .wdata (in_data),
            .raddr (rd_src),
            .rdata (bank_rdata[b])
        );
    end

    tsw_reader reader_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bank_full    (bank_full_q),
        .bank_cfg     (bank_cfg_q[rd_bank]),
        .out_ready    (out_ready),
        .out_valid    (out_valid),
        .out_idx      (out_idx),
        .tile_done    (tile_done),
        .rd_bank      (rd_bank),
        .rd_src       (rd_src),
        .bank_release (bank_release)
    );

    always_comb begin
        bank_full_d = bank_full_q;
        if (tile_loaded) begin
            bank_full_d[wr_bank] = 1'b1;
        end
        if (bank_release) begin
            bank_full_d[rd_bank] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_full_q <= '0;
            for (int i = 0; i < NBANK; i++) begin
                bank_cfg_q[i] <= '0;
            end
        end else begin
            bank_full_q <= bank_full_d;
            if (cfg_we) begin
                bank_cfg_q[wr_bank] <= cfg_in;
            end
        end
    end

    assign out_data = bank_rdata[rd_bank];
endmodule

// File: rtl/tile_rotswz_chk.sv
module tile_rotswz_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [5:0]        out_idx,
    input logic              tile_done
);
    localparam int unsigned MAX_ENTRIES = 64;
    logic [6:0] emit_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emit_cnt <= '0;
        end else if (tile_done) begin
            emit_cnt <= '0;
        end else if (out_valid && out_ready) begin
            emit_cnt <= emit_cnt + 1'b1;
        end
    end

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_idx)));

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        tile_done |=> !tile_done);

    a_r11_done_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tile_done |-> !out_valid);

    a_r9_entry_count: assert property (@(posedge clk) disable iff (!rst_n)
        tile_done |-> (emit_cnt != 0 && emit_cnt[2:0] == 3'd0 && emit_cnt <= 7'(MAX_ENTRIES)));
endmodule

bind tile_rotswz tile_rotswz_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_idx   (out_idx),
    .tile_done (tile_done)
);

// File: tb/tile_rotswz_tb_top.sv
module tile_rotswz_tb_top;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [1:0]        cfg_rot;
    logic              cfg_zorder;
    logic [2:0]        cfg_rows_m1;
    logic              in_valid;
    logic [DATA_W-1:0] in_data;
    logic              in_ready;
    logic              out_valid;
    logic              out_ready;
    logic [DATA_W-1:0] out_data;
    logic [5:0]        out_idx;
    logic              tile_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tile_rotswz #(.DATA_W(DATA_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_rot     (cfg_rot),
        .cfg_zorder  (cfg_zorder),
        .cfg_rows_m1 (cfg_rows_m1),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_ready    (in_ready),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_data    (out_data),
        .out_idx     (out_idx),
        .tile_done   (tile_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pix(input int id, input int n);
        return (32'(id) << 16) | 32'h0000_A500 | 32'(n);
    endfunction

    // Source entry for output step k, from the rotation requirements.
    function automatic int exp_src(input int k, input int rot, input int rm1);
        int h = rm1 + 1;
        case (rot)
            0: return k;
            1: return (h - 1 - (k % h)) * 8 + (k / h);
            2: return h * 8 - 1 - k;
            default: return (k % h) * 8 + (7 - (k / h));
        endcase
    endfunction

    function automatic int exp_idx(input int k, input int blk);
        int r = 0;
        if (blk == 0) return k;
        for (int b = 0; b < 3; b++) begin
            r |= ((k >> b) & 1) << (2 * b);
            r |= ((k >> (3 + b)) & 1) << (2 * b + 1);
        end
        return r;
    endfunction

    // Drives one tile; optional scramble changes config after the first word (R2).
    task automatic load_tile(input int id, input int rot, input int blk, input int rm1,
                             input bit scramble);
        cfg_rot     = 2'(rot);
        cfg_zorder  = blk[0];
        cfg_rows_m1 = 3'(rm1);
        for (int i = 0; i < (rm1 + 1) * 8; i++) begin
            in_valid = 1'b1;
            in_data  = pix(id, i);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            if (scramble && i == 0) begin
                cfg_rot     = 2'(rot + 1);
                cfg_zorder  = ~blk[0];
                cfg_rows_m1 = 3'd7;
            end
        end
        in_valid = 1'b0;
    endtask

    task automatic drain_tile(input int id, input int rot, input int blk, input int rm1,
                              input bit stall, input string req);
        int n = (rm1 + 1) * 8;
        int k = 0;
        int cyc = 0;
        bit held_v = 1'b0;
        logic [31:0] held_d = '0;
        string ireq = (blk != 0) ? "R8" : "R7";
        while (k < n) begin
            @(negedge clk);
            cyc++;
            out_ready = !(stall && (cyc % 3 == 0));
            if (held_v && out_valid) begin
                check(out_data == held_d, "R10", "held data", out_data, held_d);
            end
            held_v = 1'b0;
            if (out_valid && !out_ready) begin
                held_v = 1'b1;
                held_d = out_data;
            end
            if (out_valid && out_ready) begin
                check(out_data == pix(id, exp_src(k, rot, rm1)), req, "data",
                      out_data, pix(id, exp_src(k, rot, rm1)));
                check(int'(out_idx) == exp_idx(k, blk), ireq, "index",
                      out_idx, exp_idx(k, blk));
                k++;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        check(tile_done == 1'b1, "R11", "done after last", tile_done, 1);
        check(out_valid == 1'b0, "R9", "no extra entry", out_valid, 0);
        @(negedge clk);
        check(tile_done == 1'b0, "R11", "done width", tile_done, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
        cfg_rot = '0; cfg_zorder = 1'b0; cfg_rows_m1 = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
        check(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        check(tile_done == 1'b0, "R1", "tile_done", tile_done, 0);
    endtask

    task automatic t_rot0_linear();
        load_tile(1, 0, 0, 7, 1'b0);
        drain_tile(1, 0, 0, 7, 1'b0, "R3");
    endtask

    task automatic t_rot90_zorder_stall();
        load_tile(2, 1, 1, 7, 1'b0);
        drain_tile(2, 1, 1, 7, 1'b1, "R4");
    endtask

    task automatic t_rot180_partial_scramble();
        load_tile(3, 2, 0, 2, 1'b1);
        drain_tile(3, 2, 0, 2, 1'b0, "R5");
    endtask

    task automatic t_rot270_partial_zorder();
        load_tile(4, 3, 1, 4, 1'b0);
        drain_tile(4, 3, 1, 4, 1'b1, "R6");
    endtask

    task automatic t_single_row();
        load_tile(5, 1, 0, 0, 1'b0);
        drain_tile(5, 1, 0, 0, 1'b0, "R9");
    endtask

    task automatic t_overlap();
        fork
            begin
                load_tile(6, 2, 1, 7, 1'b0);
                load_tile(7, 0, 0, 6, 1'b0);
            end
            begin
                drain_tile(6, 2, 1, 7, 1'b1, "R12");
                drain_tile(7, 0, 0, 6, 1'b0, "R12");
            end
        join
    endtask

    task automatic t_both_full();
        load_tile(8, 0, 1, 0, 1'b0);
        load_tile(9, 3, 0, 1, 1'b0);
        repeat (2) @(negedge clk);
        check(in_ready == 1'b0, "R12", "in_ready with both banks full", in_ready, 0);
        check(out_valid == 1'b1, "R12", "first tile pending", out_valid, 1);
        drain_tile(8, 0, 1, 0, 1'b0, "R3");
        check(in_ready == 1'b1, "R12", "in_ready after release", in_ready, 1);
        drain_tile(9, 3, 0, 1, 1'b0, "R6");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_rot0_linear();
        t_rot90_zorder_stall();
        t_rot180_partial_scramble();
        t_rot270_partial_zorder();
        t_single_row();
        t_overlap();
        t_both_full();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule